// File: doc/BRIEF.md
# Fast Ethernet link integrity monitor

This block decides whether a 100 Mbps receive link is up. It samples two flags from the receive path on a symbol-rate clock enable: the descrambler lock flag and a per-symbol idle indication. While the link is down, a qualification timer counts enabled symbols with lock held. Any sample without lock restarts it, and link is declared once the full settling interval has passed. While the link is up, the block asks each window of symbols to contain a run of consecutive idle symbols. A run may begin in the previous window and carry over. A window that closes without such a run takes the link down. Stray non-idle symbols and brief lock dropouts therefore do not end the link.

A link failure sets a sticky failure bit that stays set until a clear strobe arrives. It also fires a one-cycle interrupt pulse, and a renegotiation-request pulse when auto-negotiation is enabled. Transmission is permitted while the link is up. With auto-negotiation disabled, an override input also permits transmission while the link is down. With auto-negotiation enabled and the link down, the block requests negotiation bursts instead of data.

The settling interval, the window length and the required idle run length are parameters. Their defaults are 50 ms and 2 ms at 125 Msymbol/s, with a run of 16 symbols.

Top module: `link_integrity_mon`

## Requirements
- R1: While down, link_o rises at the clock edge that samples the QUAL_CNT-th consecutive enabled symbol with lock_i high. An enabled symbol with lock_i low restarts the count from zero.
- R2: While up, a window is WIN_CNT enabled symbols long. The window counts from the symbol after link rise, or after the previous window closed. If no enabled symbol in the window completes or extends a run of IDLE_RUN consecutive idle symbols, link_o falls at the edge that samples the window's last symbol. An idle run may start in an earlier window.
- R3: While up, non-idle symbols and lock_i low do not drop the link as long as every window meets the rule in R2.
- R4: link_fail_o goes to 1 at the edge where link_o falls and stays 1 until fail_clr_i is high at a clock edge. A new failure at the same edge wins over the clear.
- R5: irq_o is a single-cycle pulse, high for the cycle after the edge where link_o falls.
- R6: reneg_o pulses together with irq_o only when an_en_i is 1 at that edge. Otherwise it stays 0.
- R7: tx_permit_o is 1 when link_o is 1, or when override_i is 1 and an_en_i is 0. Otherwise it is 0.
- R8: flp_req_o is 1 exactly when link_o is 0 and an_en_i is 1.
- R9: After reset the link is down, link_fail_o, irq_o and reneg_o are 0, and all counters restart from zero.
- R10: Clock edges with sym_en_i low do not advance or clear any timer, run counter or link state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_en_i | input | 1 | Symbol-rate enable; inputs are sampled only when high |
| lock_i | input | 1 | Descrambler lock flag |
| idle_i | input | 1 | Current symbol is idle |
| an_en_i | input | 1 | Auto-negotiation enabled |
| override_i | input | 1 | Permit transmission with link down |
| fail_clr_i | input | 1 | Clear strobe for the sticky failure bit |
| link_o | output | 1 | Live link level |
| link_fail_o | output | 1 | Sticky link-failure status |
| irq_o | output | 1 | Interrupt pulse on link failure |
| reneg_o | output | 1 | Renegotiation request pulse |
| tx_permit_o | output | 1 | Data transmission permitted |
| flp_req_o | output | 1 | Request negotiation bursts |

## Verification
The assertions take for granted that every input is synchronous to clk_i and holds a known value from the first edge after reset. They also take for granted that fail_clr_i is sampled like any other level, so it may be held high for several cycles. The bench changes its inputs only just after the falling edge and never leaves them unknown. It gaps sym_en_i both at random and over long stretches, which exercises the assumption that counting depends on the enable alone.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_state_e;
endpackage

// File: rtl/lim_qual_timer.sv
module lim_qual_timer #(
  parameter int unsigned QUAL_CNT = 6_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lock_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned QW = (QUAL_CNT > 2) ? $clog2(QUAL_CNT) : 1;
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CNT - 1);

  logic [QW-1:0] cnt_q;

  assign done_o = tick_i & lock_i & (cnt_q == QLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (tick_i) begin
      if (!lock_i || done_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lim_idle_window.sv
module lim_idle_window #(
  parameter int unsigned WIN_CNT  = 250_000,
  parameter int unsigned IDLE_RUN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic idle_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int unsigned WW = (WIN_CNT > 2) ? $clog2(WIN_CNT) : 1;
  localparam int unsigned RW = $clog2(IDLE_RUN + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CNT - 1);
  localparam logic [RW-1:0] RMAX  = RW'(IDLE_RUN);
  localparam logic [RW-1:0] RNEED = RW'(IDLE_RUN - 1);

  logic [WW-1:0] win_q;
  logic [RW-1:0] run_q;
  logic          seen_q;
  logic          hit, boundary;

  // current symbol completes or extends a qualifying run
  assign hit      = tick_i & idle_i & (run_q >= RNEED);
  assign boundary = tick_i & (win_q == WLAST);
  assign expire_o = boundary & ~(seen_q | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      win_q  <= '0;
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_i) begin
      if (!idle_i)            run_q <= '0;
      else if (run_q != RMAX) run_q <= run_q + 1'b1;
      win_q  <= boundary ? '0 : win_q + 1'b1;
      seen_q <= boundary ? 1'b0 : (seen_q | hit);
    end
  end
endmodule

// File: rtl/lim_status.sv
module lim_status
  import lim_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic down_i,
  input  logic an_en_i,
  input  logic override_i,
  input  logic fail_clr_i,
  output logic link_o,
  output logic link_fail_o,
  output logic irq_o,
  output logic reneg_o,
  output logic tx_permit_o,
  output logic flp_req_o
);
  link_state_e state_q, state_d;
  logic        fall;
  logic        fail_q, irq_q, reneg_q;

  always_comb begin
    state_d = state_q;
    fall    = 1'b0;
    unique case (state_q)
      LINK_DOWN: if (up_i) state_d = LINK_UP;
      LINK_UP: if (down_i) begin
        state_d = LINK_DOWN;
        fall    = 1'b1;
      end
      default: state_d = LINK_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINK_DOWN;
      fail_q  <= 1'b0;
      irq_q   <= 1'b0;
      reneg_q <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= fall;
      reneg_q <= fall & an_en_i;
      if (fall)            fail_q <= 1'b1;
      else if (fail_clr_i) fail_q <= 1'b0;
    end
  end

  assign link_o      = (state_q == LINK_UP);
  assign link_fail_o = fail_q;
  assign irq_o       = irq_q;
  assign reneg_o     = reneg_q;
  assign tx_permit_o = link_o | (override_i & ~an_en_i);
  assign flp_req_o   = ~link_o & an_en_i;
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int unsigned QUAL_CNT = 6_250_000,
  parameter int unsigned WIN_CNT  = 250_000,
  parameter int unsigned IDLE_RUN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sym_en_i,
  input  logic lock_i,
  input  logic idle_i,
  input  logic an_en_i,
  input  logic override_i,
  input  logic fail_clr_i,
  output logic link_o,
  output logic link_fail_o,
  output logic irq_o,
  output logic reneg_o,
  output logic tx_permit_o,
  output logic flp_req_o
);
  logic qual_done, win_expire;

  lim_qual_timer #(.QUAL_CNT(QUAL_CNT)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (sym_en_i & ~link_o),
    .lock_i (lock_i),
    .clr_i  (link_o),
    .done_o (qual_done)
  );

  lim_idle_window #(.WIN_CNT(WIN_CNT), .IDLE_RUN(IDLE_RUN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (sym_en_i & link_o),
    .idle_i   (idle_i),
    .clr_i    (~link_o),
    .expire_o (win_expire)
  );

  lim_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .up_i        (qual_done),
    .down_i      (win_expire),
    .an_en_i     (an_en_i),
    .override_i  (override_i),
    .fail_clr_i  (fail_clr_i),
    .link_o      (link_o),
    .link_fail_o (link_fail_o),
    .irq_o       (irq_o),
    .reneg_o     (reneg_o),
    .tx_permit_o (tx_permit_o),
    .flp_req_o   (flp_req_o)
  );
endmodule

// File: rtl/lim_checker.sv
module lim_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sym_en_i,
  input logic lock_i,
  input logic an_en_i,
  input logic fail_clr_i,
  input logic link_o,
  input logic link_fail_o,
  input logic irq_o,
  input logic reneg_o
);
  a_r1_rise_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_o) |-> $past(lock_i && sym_en_i));

  a_r4_fail_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_o) |-> link_fail_o);

  a_r4_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_fail_o && !fail_clr_i) |=> link_fail_o);

  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_irq_with_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $fell(link_o));

  a_r6_reneg_needs_an: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reneg_o |-> (irq_o && $past(an_en_i)));

  a_r10_hold_without_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sym_en_i) |-> $stable(link_o));
endmodule

bind link_integrity_mon lim_checker u_lim_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_en_i    (sym_en_i),
  .lock_i      (lock_i),
  .an_en_i     (an_en_i),
  .fail_clr_i  (fail_clr_i),
  .link_o      (link_o),
  .link_fail_o (link_fail_o),
  .irq_o       (irq_o),
  .reneg_o     (reneg_o)
);

// File: tb/tb_link_integrity_mon.sv
`timescale 1ns/1ps
module tb_link_integrity_mon;
  localparam int QUAL = 50;
  localparam int WIN  = 64;
  localparam int RUN  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sym_en = 1'b0, lock = 1'b0, idle = 1'b0;
  logic an_en = 1'b1, override = 1'b0, fail_clr = 1'b0;
  logic link, link_fail, irq, reneg, tx_permit, flp_req;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  link_integrity_mon #(.QUAL_CNT(QUAL), .WIN_CNT(WIN), .IDLE_RUN(RUN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sym_en_i(sym_en), .lock_i(lock), .idle_i(idle),
    .an_en_i(an_en), .override_i(override), .fail_clr_i(fail_clr),
    .link_o(link), .link_fail_o(link_fail), .irq_o(irq), .reneg_o(reneg),
    .tx_permit_o(tx_permit), .flp_req_o(flp_req));

  // behavioural reference
  bit m_link, m_fail, m_irq, m_reneg;
  int q_cnt, w_cnt, r_cnt;
  bit seen;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_link = 0; m_fail = 0; m_irq = 0; m_reneg = 0;
      q_cnt = 0; w_cnt = 0; r_cnt = 0; seen = 0;
    end else begin
      bit fall, hit;
      fall = 0;
      if (sym_en) begin
        if (!m_link) begin
          if (!lock) q_cnt = 0;
          else begin
            q_cnt++;
            if (q_cnt == QUAL) begin
              m_link = 1; q_cnt = 0; w_cnt = 0; r_cnt = 0; seen = 0;
            end
          end
        end else begin
          hit = idle && (r_cnt + 1 >= RUN);
          r_cnt = idle ? ((r_cnt < RUN) ? r_cnt + 1 : RUN) : 0;
          if (hit) seen = 1;
          w_cnt++;
          if (w_cnt == WIN) begin
            if (!seen) begin
              fall = 1; m_link = 0; q_cnt = 0;
            end
            w_cnt = 0; seen = 0;
          end
        end
      end
      m_irq = fall;
      m_reneg = fall && an_en;
      if (fall) m_fail = 1;
      else if (fail_clr) m_fail = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R1 R2 R3 link_o", link, m_link);
      chk("R4 link_fail_o", link_fail, m_fail);
      chk("R5 irq_o", irq, m_irq);
      chk("R6 reneg_o", reneg, m_reneg);
      chk("R7 tx_permit_o", tx_permit, m_link || (override && !an_en));
      chk("R8 flp_req_o", flp_req, !m_link && an_en);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input logic en, input logic lk, input logic id);
    sym_en = en; lock = lk; idle = id;
    @(negedge clk); #1;
  endtask

  task automatic qualify();
    for (int i = 0; i < QUAL; i++) step(1, 1, 1);
  endtask

  task automatic fail_link();
    for (int i = 0; i < 3 * WIN && link; i++) step(1, 1, 0);
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk("R9 link after reset", link, 0);
    chk("R9 fail after reset", link_fail, 0);
    chk("R9 irq after reset", irq, 0);
    chk("R9 reneg after reset", reneg, 0);
    rst_ni = 1'b1;
    step(0, 0, 0);

    // R1 restart on lock glitch
    for (int i = 0; i < 30; i++) step(1, 1, 1);
    step(1, 0, 1);
    for (int i = 0; i < QUAL - 1; i++) step(1, 1, 1);
    chk("R1 not yet up after glitch", link, 0);
    step(1, 1, 1);
    chk("R1 up after full interval", link, 1);

    // R3 noise and lock loss with runs kept
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 20; i++) step(1, 1, 1);
      for (int i = 0; i < 40; i++) step(1, (i % 7) != 0, (i % 3) == 0);
    end
    chk("R3 link kept through noise", link, 1);

    // R10 enable held low
    for (int i = 0; i < 4 * WIN; i++) step(0, 0, 0);
    chk("R10 link held without enable", link, 1);

    // R2 continuous idle crosses windows
    for (int i = 0; i < 3 * WIN; i++) step(1, 1, 1);
    chk("R2 long idle keeps link", link, 1);

    // R2 R4 R5 R6 failure with auto-negotiation on
    fail_link();
    chk("R2 link dropped", link, 0);
    chk("R4 fail set", link_fail, 1);
    chk("R5 irq pulse", irq, 1);
    chk("R6 reneg with an", reneg, 1);
    step(0, 0, 0);
    chk("R5 irq one cycle", irq, 0);
    chk("R8 flp while down", flp_req, 1);
    chk("R4 fail sticky", link_fail, 1);
    fail_clr = 1'b1; step(0, 0, 0); fail_clr = 1'b0;
    chk("R4 fail cleared", link_fail, 0);

    // R7 override with auto-negotiation off
    an_en = 1'b0; override = 1'b1;
    step(0, 0, 0);
    chk("R7 tx permitted via override", tx_permit, 1);
    chk("R8 no flp with an off", flp_req, 0);
    an_en = 1'b1;
    step(0, 0, 0);
    chk("R7 override ignored with an on", tx_permit, 0);
    an_en = 1'b0;

    // R6 failure with an off; R4 set wins over clear
    qualify();
    chk("R1 requalified", link, 1);
    for (int i = 0; i < 3 * WIN && link; i++) begin
      fail_clr = 1'b1;
      step(1, 1, 0);
    end
    fail_clr = 1'b0;
    chk("R4 set wins over clear", link_fail, 1);
    chk("R6 no reneg with an off", reneg, 0);
    chk("R5 irq with an off", irq, 1);
    override = 1'b0;
    an_en = 1'b1;

    // random mix, model compared each cycle
    for (int i = 0; i < 20000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fail_clr = (lfsr[9:6] == 4'h0);
      if (i % 3000 == 1500) an_en = ~an_en;
      step(lfsr[1:0] != 2'b00, lfsr[14:11] != 4'h0, (i % 90) < 40 || lfsr[3]);
    end
    fail_clr = 1'b0;

    step(0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule